// File: doc/BRIEF.md
# Sponge Absorb Block Assembler

This block assembles the rate blocks for a SHAKE256 absorb whose message is a short secret followed by a ciphertext stored in a byte-wide memory with a one-cycle registered read. It walks a global byte index across the padded message. Each byte comes from the secret register, from the memory, or from a padding constant. Each finished 136-byte block is offered to a sponge core as one 1088-bit word with a valid/last/ack handshake. When the core reports that the digest is ready, the block keeps the digest as its result and raises done.

The walker is meant to run in the background next to a main controller. While it is active it drives the memory read address and the sponge's multi-block input. While it is idle, both pass straight through from another requester. The ciphertext length is selected at start by the parameter set K: 768, 1088 or 1568 bytes.

Top module: `absorb_walker`

## Requirements
- R1: A start pulse latches `k_sel_i`, clears done, and makes the walker active on the next cycle with block and byte counters at zero. A start also restarts a run already in progress from global byte 0. The ciphertext size is 32*(du*K+dv): du=11 and dv=5 when `k_sel_i`=4, giving 1568 bytes; du=10 and dv=4 otherwise. `k_sel_i`=3 gives 1088 bytes and any other value gives K=2 and 768 bytes. Changes of `k_sel_i` after the start have no effect.
- R2: Global byte g below SECRET_BYTES takes secret byte g, which is `secret_i[8g+7:8g]`.
- R3: Global byte g with SECRET_BYTES <= g < message length (SECRET_BYTES + ciphertext size) takes the memory byte at address g-SECRET_BYTES. That address is on `mem_addr_o` in the cycle before the byte is written into the block.
- R4: Bytes at or beyond the message length are padding: 0x1F at g equal to the message length, 0x80 in the last byte of the final block, 0x9F when these fall on the same byte, and 0x00 elsewhere. A run has floor(length/136)+1 blocks.
- R5: Block byte i appears on `blk_o[8i+7:8i]`. Valid rises 137 cycles after a start or after the ack of the previous block, and stays high with unchanged contents until `blk_ack_i`. `blk_last_o` is high only with the final block.
- R6: While active, the walker alone drives `mem_addr_o` and the sponge block port, and its block valid is low outside an offer. While idle, these outputs equal `ext_addr_i`, `ext_blk_i`, `ext_blk_valid_i` and `ext_blk_last_i`.
- R7: After the final ack, a `digest_valid_i` pulse stores `digest_i` into `result_o`. On the next cycle done is high and active is low. A digest pulse at any other time leaves the result and done unchanged.
- R8: After reset, active, done and the walker's block valid are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start (or restart) pulse |
| k_sel_i | input | 3 | Parameter set K, sampled at start |
| secret_i | input | 8*SECRET_BYTES | Secret prefix, byte j in bits [8j+7:8j] |
| ext_addr_i | input | ADDR_W | Memory address of the other requester |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_data_i | input | 8 | Registered memory read data |
| ext_blk_i | input | 8*RATE_BYTES | Block word of the other requester |
| ext_blk_valid_i | input | 1 | Valid of the other requester |
| ext_blk_last_i | input | 1 | Last of the other requester |
| blk_o | output | 8*RATE_BYTES | Block word to the sponge |
| blk_valid_o | output | 1 | Block valid to the sponge |
| blk_last_o | output | 1 | Final block marker |
| blk_ack_i | input | 1 | Sponge accepted the offered block |
| digest_valid_i | input | 1 | Sponge digest ready |
| digest_i | input | RES_W | Low digest bits from the sponge |
| result_o | output | RES_W | Captured digest |
| done_o | output | 1 | Run finished |
| active_o | output | 1 | Walker owns memory and sponge port |

## Verification
On every cycle the assertions check four things: a start clears done, a held block stays unchanged until it is acked, last never appears without valid, and the block counter never passes the final block. They also check that the result changes only on a digest pulse in the waiting phase. Byte contents, padding placement, memory address order and pass-through ownership can only be shown by the bench scenarios. These compare whole blocks against a behavioural model for each K, for secret lengths that place the 0x1F byte at a block start, and for a length that merges both padding bits into 0x9F. They also cover a restart in the middle of a block.

// File: rtl/aw_pkg.sv
package aw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_OFFER,
    ST_DIGEST
  } aw_state_e;

  typedef enum logic [1:0] {
    SRC_SECRET,
    SRC_MEM,
    SRC_PAD
  } aw_src_e;

  localparam logic [7:0] PAD_FIRST = 8'h1F;
  localparam logic [7:0] PAD_FINAL = 8'h80;

  // Ciphertext byte count for parameter set K: 32*(du*K + dv)
  function automatic int unsigned ct_bytes(input logic [2:0] k);
    int unsigned kk, du, dv;
    kk = (k == 3'd4) ? 4 : ((k == 3'd3) ? 3 : 2);
    du = (kk == 4) ? 11 : 10;
    dv = (kk == 4) ? 5 : 4;
    return 32 * (du * kk + dv);
  endfunction

endpackage

// File: rtl/aw_len_calc.sv
module aw_len_calc
  import aw_pkg::*;
#(
  parameter int unsigned SECRET_BYTES = 32,
  parameter int unsigned RATE_BYTES   = 136,
  parameter int unsigned G_W          = 11,
  parameter int unsigned BLK_W        = 4
) (
  input  logic [2:0]       k_i,
  output logic [G_W-1:0]   msg_len_o,
  output logic [G_W-1:0]   pad_last_o,
  output logic [BLK_W-1:0] last_blk_o
);

  always_comb begin
    int unsigned ml, lb;
    ml         = SECRET_BYTES + ct_bytes(k_i);
    lb         = ml / RATE_BYTES;
    msg_len_o  = G_W'(ml);
    last_blk_o = BLK_W'(lb);
    pad_last_o = G_W'((lb + 1) * RATE_BYTES - 1);
  end

endmodule

// File: rtl/aw_byte_src.sv
module aw_byte_src
  import aw_pkg::*;
#(
  parameter int unsigned SECRET_BYTES = 32,
  parameter int unsigned G_W          = 11,
  parameter int unsigned ADDR_W       = 11
) (
  input  logic [G_W-1:0]            g_i,
  input  logic [G_W-1:0]            msg_len_i,
  input  logic [G_W-1:0]            pad_last_i,
  input  logic [SECRET_BYTES*8-1:0] secret_i,
  output aw_src_e                   src_o,
  output logic [7:0]                const_o,
  output logic [ADDR_W-1:0]         addr_o
);

  localparam int unsigned SB_W = $clog2(SECRET_BYTES);

  logic [7:0] sec_b [SECRET_BYTES];

  for (genvar j = 0; j < SECRET_BYTES; j++) begin : g_sec
    assign sec_b[j] = secret_i[j*8 +: 8];
  end

  always_comb begin
    src_o   = SRC_PAD;
    const_o = '0;
    addr_o  = '0;
    if (g_i < G_W'(SECRET_BYTES)) begin
      src_o   = SRC_SECRET;
      const_o = sec_b[g_i[SB_W-1:0]];
    end else if (g_i < msg_len_i) begin
      src_o  = SRC_MEM;
      addr_o = ADDR_W'(g_i - G_W'(SECRET_BYTES));
    end else begin
      if (g_i == msg_len_i)  const_o = const_o | PAD_FIRST;
      if (g_i == pad_last_i) const_o = const_o | PAD_FINAL;
    end
  end

endmodule

// File: rtl/aw_block_buf.sv
module aw_block_buf #(
  parameter int unsigned RATE_BYTES = 136,
  parameter int unsigned POS_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en_i,
  input  logic [POS_W-1:0]        wr_pos_i,
  input  logic [7:0]              wr_byte_i,
  output logic [RATE_BYTES*8-1:0] blk_o
);

  for (genvar i = 0; i < RATE_BYTES; i++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) byte_q <= '0;
      else if (wr_en_i && wr_pos_i == POS_W'(i)) byte_q <= wr_byte_i;
    end
    assign blk_o[i*8 +: 8] = byte_q;
  end

  // write position always lands inside the rate block
  assert_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> (wr_pos_i < POS_W'(RATE_BYTES)));

endmodule

// File: rtl/absorb_walker.sv
module absorb_walker
  import aw_pkg::*;
#(
  parameter int unsigned SECRET_BYTES = 32,
  parameter int unsigned RATE_BYTES   = 136,
  parameter int unsigned MAX_BLOCKS   = 12,
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned RES_W        = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [2:0]                k_sel_i,
  input  logic [SECRET_BYTES*8-1:0] secret_i,
  input  logic [ADDR_W-1:0]         ext_addr_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  input  logic [7:0]                mem_data_i,
  input  logic [RATE_BYTES*8-1:0]   ext_blk_i,
  input  logic                      ext_blk_valid_i,
  input  logic                      ext_blk_last_i,
  output logic [RATE_BYTES*8-1:0]   blk_o,
  output logic                      blk_valid_o,
  output logic                      blk_last_o,
  input  logic                      blk_ack_i,
  input  logic                      digest_valid_i,
  input  logic [RES_W-1:0]          digest_i,
  output logic [RES_W-1:0]          result_o,
  output logic                      done_o,
  output logic                      active_o
);

  localparam int unsigned G_W   = $clog2(MAX_BLOCKS * RATE_BYTES);
  localparam int unsigned BLK_W = $clog2(MAX_BLOCKS);
  localparam int unsigned POS_W = $clog2(RATE_BYTES + 1);

  aw_state_e               state;
  logic [2:0]              k_q;
  logic [BLK_W-1:0]        blk_cnt, last_blk;
  logic [POS_W-1:0]        byte_cnt;
  logic [G_W-1:0]          g, msg_len, pad_last;
  aw_src_e                 src;
  logic [7:0]              src_const;
  logic [ADDR_W-1:0]       src_addr;
  logic                    wb_en, wb_mem;
  logic [POS_W-1:0]        wb_pos;
  logic [7:0]              wb_const, wr_byte;
  logic [RATE_BYTES*8-1:0] own_blk;
  logic                    own_valid, own_last;
  logic [RES_W-1:0]        result_q;
  logic                    done_q;
  logic                    active;

  // sizes for the latched parameter set
  aw_len_calc #(
    .SECRET_BYTES(SECRET_BYTES), .RATE_BYTES(RATE_BYTES),
    .G_W(G_W), .BLK_W(BLK_W)
  ) u_len (
    .k_i(k_q), .msg_len_o(msg_len), .pad_last_o(pad_last), .last_blk_o(last_blk)
  );

  // global index of the byte issued this cycle
  always_comb g = G_W'(blk_cnt) * G_W'(RATE_BYTES) + G_W'(byte_cnt);

  aw_byte_src #(
    .SECRET_BYTES(SECRET_BYTES), .G_W(G_W), .ADDR_W(ADDR_W)
  ) u_src (
    .g_i(g), .msg_len_i(msg_len), .pad_last_i(pad_last), .secret_i(secret_i),
    .src_o(src), .const_o(src_const), .addr_o(src_addr)
  );

  // writeback stage: memory bytes arrive one cycle after their address
  assign wr_byte = wb_mem ? mem_data_i : wb_const;

  aw_block_buf #(
    .RATE_BYTES(RATE_BYTES), .POS_W(POS_W)
  ) u_buf (
    .clk(clk), .rst(rst), .wr_en_i(wb_en), .wr_pos_i(wb_pos),
    .wr_byte_i(wr_byte), .blk_o(own_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      k_q       <= '0;
      blk_cnt   <= '0;
      byte_cnt  <= '0;
      wb_en     <= 1'b0;
      wb_mem    <= 1'b0;
      wb_pos    <= '0;
      wb_const  <= '0;
      own_valid <= 1'b0;
      own_last  <= 1'b0;
      result_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      wb_en <= 1'b0;
      if (start_i) begin
        state     <= ST_FILL;
        k_q       <= k_sel_i;
        blk_cnt   <= '0;
        byte_cnt  <= '0;
        own_valid <= 1'b0;
        own_last  <= 1'b0;
        done_q    <= 1'b0;
      end else begin
        case (state)
          ST_FILL: begin
            if (byte_cnt < POS_W'(RATE_BYTES)) begin
              wb_en    <= 1'b1;
              wb_pos   <= byte_cnt;
              wb_mem   <= (src == SRC_MEM);
              wb_const <= src_const;
              byte_cnt <= byte_cnt + POS_W'(1);
            end else begin
              own_valid <= 1'b1;
              own_last  <= (blk_cnt == last_blk);
              state     <= ST_OFFER;
            end
          end
          ST_OFFER: begin
            if (blk_ack_i) begin
              own_valid <= 1'b0;
              own_last  <= 1'b0;
              if (own_last) begin
                state <= ST_DIGEST;
              end else begin
                blk_cnt  <= blk_cnt + BLK_W'(1);
                byte_cnt <= '0;
                state    <= ST_FILL;
              end
            end
          end
          ST_DIGEST: begin
            if (digest_valid_i) begin
              result_q <= digest_i;
              done_q   <= 1'b1;
              state    <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign active = (state != ST_IDLE);

  // ownership of the shared memory port and sponge input
  assign mem_addr_o  = active ? src_addr  : ext_addr_i;
  assign blk_o       = active ? own_blk   : ext_blk_i;
  assign blk_valid_o = active ? own_valid : ext_blk_valid_i;
  assign blk_last_o  = active ? own_last  : ext_blk_last_i;

  assign result_o = result_q;
  assign done_o   = done_q;
  assign active_o = active;

  assert_start_clears_done_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!done_o && active_o));

  assert_block_bound_R4: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (blk_cnt <= last_blk));

  assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    own_last |-> own_valid);

  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OFFER && !blk_ack_i && !start_i) |=> (own_valid && $stable(own_blk)));

  assert_done_not_active_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !active_o);

  assert_digest_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DIGEST && digest_valid_i && !start_i) |=>
      (done_o && result_o == $past(digest_i)));

  assert_result_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !(state == ST_DIGEST && digest_valid_i) |=> $stable(result_o));

endmodule

// File: tb/absorb_walker_tb.sv
module aw_lane #(
  parameter int SB   = 32,
  parameter int LANE = 0
) (
  input  logic clk,
  input  logic rst,
  output int   n_chk,
  output int   n_bad,
  output logic fin
);

  logic            start = 0, ack = 0, dv = 0, ext_valid = 1, ext_last = 0;
  logic [2:0]      k_sel = 3'd2;
  logic [SB*8-1:0] secret;
  logic [10:0]     ext_addr = 11'h5A5;
  logic [10:0]     mem_addr;
  logic [7:0]      mem_q = 0;
  logic [1087:0]   ext_blk, blk;
  logic            blk_valid, blk_last, done, active;
  logic [255:0]    digest = 0, result;
  logic [7:0]      mem [2048];

  absorb_walker #(.SECRET_BYTES(SB)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .k_sel_i(k_sel), .secret_i(secret),
    .ext_addr_i(ext_addr), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .ext_blk_i(ext_blk), .ext_blk_valid_i(ext_valid), .ext_blk_last_i(ext_last),
    .blk_o(blk), .blk_valid_o(blk_valid), .blk_last_o(blk_last), .blk_ack_i(ack),
    .digest_valid_i(dv), .digest_i(digest), .result_o(result),
    .done_o(done), .active_o(active)
  );

  // registered-read memory model
  always @(posedge clk) mem_q <= mem[mem_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [1087:0] act, input logic [1087:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s lane%0d %s: actual %h expected %h", req, LANE, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sec_byte(input int j);
    return 8'(8'hA0 ^ (j * 5) ^ LANE);
  endfunction

  function automatic logic [7:0] exp_byte(input int g, input int mlen, input int lastg);
    logic [7:0] b;
    if (g < SB) return sec_byte(g);
    if (g < mlen) return mem[g - SB];
    b = 8'h00;
    if (g == mlen)  b = b | 8'h1F;
    if (g == lastg) b = b | 8'h80;
    return b;
  endfunction

  function automatic logic [1087:0] exp_block(input int bl, input int mlen, input int lastg);
    logic [1087:0] v;
    for (int i = 0; i < 136; i++) v[i*8 +: 8] = exp_byte(bl*136 + i, mlen, lastg);
    return v;
  endfunction

  task automatic run(input int k, input int dly, input int restart_b, input bit junk_dv);
    int ct, mlen, nblk, lastg, g;
    bit restarted;
    logic [1087:0] eb;
    logic [255:0] dig, old_res;
    ct    = (k == 4) ? 1568 : ((k == 3) ? 1088 : 768);
    mlen  = SB + ct;
    nblk  = mlen / 136 + 1;
    lastg = nblk * 136 - 1;
    restarted = 0;
    @(negedge clk);
    k_sel = 3'(k); start = 1;
    @(negedge clk);
    start = 0; k_sel = 3'd7;  // later changes must not matter (R1)
    chk(active && !done, "R1", "active after start", {active, done}, 2'b10);
    for (int bl = 0; bl < nblk; bl++) begin
      for (int b = 0; b <= 136; b++) begin
        g = bl * 136 + b;
        if (dv) begin dv = 0; digest = 0; end
        chk(!blk_valid, "R6", "valid low while filling", blk_valid, 0);
        if (b < 136 && g >= SB && g < mlen)
          chk(mem_addr == 11'(g - SB), "R3", "memory address", mem_addr, 11'(g - SB));
        if (junk_dv && bl == 0 && b == 20) begin dv = 1; digest = {8{32'hBAD0BAD0}}; end
        if (!restarted && bl == 0 && b == restart_b) begin
          restarted = 1;
          start = 1; k_sel = 3'(k);
          @(negedge clk);
          start = 0; k_sel = 3'd7;
          chk(active && !done, "R1", "restart", {active, done}, 2'b10);
          b = -1;
          continue;
        end
        @(negedge clk);
      end
      eb = exp_block(bl, mlen, lastg);
      chk(blk_valid, "R5", "valid after fill", blk_valid, 1);
      chk(blk_last == (bl == nblk - 1), "R4", "last flag", blk_last, (bl == nblk - 1));
      chk(blk == eb, "R2/R3/R4", $sformatf("block %0d contents", bl), blk, eb);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(blk_valid && blk == eb, "R5", "held until ack", blk, eb);
      end
      ack = 1;
      @(negedge clk);
      ack = 0;
    end
    for (int w = 0; w < 3; w++) begin
      chk(active && !done && !blk_valid, "R7", "waiting for digest",
          {active, done, blk_valid}, 3'b100);
      @(negedge clk);
    end
    dig = {8{32'h1000_0000 + 32'(k * 256 + dly * 16 + LANE)}};
    digest = dig; dv = 1;
    @(negedge clk);
    dv = 0; digest = '1;
    chk(done && !active, "R7", "done after digest", {done, active}, 2'b10);
    chk(result == dig, "R7", "captured result", result, dig);
    chk(mem_addr == ext_addr, "R6", "idle address passthrough", mem_addr, ext_addr);
    chk(blk == ext_blk && blk_valid == ext_valid && blk_last == ext_last, "R6",
        "idle sponge passthrough", blk, ext_blk);
    // a digest pulse while idle must be ignored (R7)
    old_res = result;
    dv = 1; digest = {8{32'h0DD0_0DD0}};
    @(negedge clk);
    dv = 0;
    @(negedge clk);
    chk(result == old_res && done, "R7", "idle digest ignored", result, old_res);
    ext_addr = ext_addr + 11'd3;
    ext_last = ~ext_last;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; fin = 0;
    for (int j = 0; j < SB; j++) secret[j*8 +: 8] = sec_byte(j);
    for (int a = 0; a < 2048; a++) mem[a] = 8'(((a * 37 + 11) ^ (a >> 3)) + LANE);
    for (int q = 0; q < 17; q++) ext_blk[q*64 +: 64] = 64'hC0FF_EE00_0000_0000 + 64'(q);
    @(negedge clk);
    while (rst) @(negedge clk);
    chk(!active && !done && result == 0, "R8", "reset state", {active, done}, 0);
    chk(blk_valid == ext_valid, "R8", "reset valid passthrough", blk_valid, ext_valid);
    if (LANE == 0) begin
      run(2, 0, -1, 0);
      run(3, 3, -1, 1);
      run(4, 1, 50, 0);
      run(2, 2, -1, 0);
    end else begin
      run(2, 2, -1, 0);
      run(3, 0, -1, 0);
    end
    fin = 1;
  end

endmodule

module absorb_walker_tb;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  int c0, b0, c1, b1, c2, b2;
  logic f0, f1, f2;

  // 32-byte secret: all three K sizes
  aw_lane #(.SB(32), .LANE(0)) u_lane0 (.clk(clk), .rst(rst), .n_chk(c0), .n_bad(b0), .fin(f0));
  // 48-byte secret, K=2: 0x1F lands on the first byte of a block (R4)
  aw_lane #(.SB(48), .LANE(1)) u_lane1 (.clk(clk), .rst(rst), .n_chk(c1), .n_bad(b1), .fin(f1));
  // 47-byte secret, K=2: both pad bits merge into 0x9F (R4)
  aw_lane #(.SB(47), .LANE(2)) u_lane2 (.clk(clk), .rst(rst), .n_chk(c2), .n_bad(b2), .fin(f2));

  initial begin
    int tot, bad;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int c = 0; c < 200000 && !(f0 && f1 && f2); c++) @(posedge clk);
    @(negedge clk);
    tot = c0 + c1 + c2;
    bad = b0 + b1 + b2;
    if (!(f0 && f1 && f2)) begin
      tot++;
      bad++;
      $display("FAIL watchdog: lanes finished %b expected 111", {f0, f1, f2});
    end
    $display("== %0d vectors applied, %0d miscompares ==", tot, bad);
    $finish;
  end

endmodule